// File: doc/BRIEF.md
# Multi-Master Memory Protection Checker

This block sits beside a shared bus and judges every access that a bus master makes. A master ID, an address, an access kind (read, write or instruction fetch) and a privilege flag go in. In the same cycle the block answers whether the access is allowed, so the bus can suppress an illegal write before it commits. The answer comes from eight programmable regions. Each region has inclusive lower and upper bounds, a per-master enable mask, a write-protect attribute and a no-execute attribute.

A denied access sets a sticky error flag and freezes the faulting address and master ID in capture registers until software clears the flag. When the main CPU (master 0) makes the illegal access, the block also raises an interrupt request that cannot be masked. That request stays up until the CPU acknowledges it with its vector fetch, not until the flag is cleared. A flag left set therefore never raises the request again.

After reset, region 0 is open to every master and the other regions are closed, so the system runs unprotected until software programs the regions.

Top module: `mpu_guard`

## Requirements
- R1: After reset every region spans 0x0000..0xFFFF, region 0 enables all masters, and regions 1..7 enable none. Write protect, no-execute, supervisor checking, the error flag and the interrupt request are all clear, so any access by any master is allowed.
- R2: An access is allowed only if at least one region satisfies all three of these conditions:
  - lower <= address <= upper, with both bounds inclusive;
  - the region's enable bit for the requesting master is set;
  - the access kind is not forbidden by the region.

  Master IDs with no enable bit are never enabled.
- R3: A region with write protect set (attribute bit 8) forbids writes (kind 1) and still permits reads (kind 0) and fetches (kind 2).
- R4: A region with no-execute set (attribute bit 9) forbids fetches (kind 2) and still permits reads.
- R5: When regions overlap, the access is allowed if any matching region permits it.
- R6: While control bit 0 (supervisor checking) is clear, master 0 with the supervisor input high is allowed regardless of the regions. Once the bit is set, that access is checked like any other.
- R7: A denied access sets the error flag (status bit 0) at the next clock edge.
- R8: A denied access by master 0 raises irq_o at the next edge. irq_o stays high until a cycle with vec_ack_i high and no new master-0 violation; it drops at the edge that ends that cycle. A denial by any other master does not raise irq_o.
- R9: irq_o rises only after a master-0 violation. An error flag that is still set never raises it again.
- R10: The first denial while the flag is clear captures the address (reg 34) and the master ID (reg 35). Later denials leave the capture unchanged. Writing 1 to status bit 0 (reg 33) clears the flag.
- R11: acc_allow_o is combinational, valid in the cycle of the request, and low whenever acc_valid_i is low.

Register map (word addresses):
- Region d uses 4d+0 (lower bound), 4d+1 (upper bound) and 4d+2 (attribute: bits [2:0] master enables, bit 8 write protect, bit 9 no-execute).
- Address 32 is control, 33 is status, 34 is the captured address and 35 is the captured master.
- Access kind encoding: 0 read, 1 write, 2 fetch, 3 treated as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address (write and read) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Combinational read data at reg_addr_i |
| acc_valid_i | input | 1 | Access request present |
| acc_master_i | input | 2 | Requesting master ID (0 is the main CPU) |
| acc_addr_i | input | 16 | Access address |
| acc_kind_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| acc_super_i | input | 1 | Requester is in supervisor state |
| acc_allow_o | output | 1 | Access allowed, same cycle |
| irq_o | output | 1 | Access violation interrupt request |
| vec_ack_i | input | 1 | CPU vector fetch acknowledge |

## Verification
The assertions rely on two things about the inputs: the access and acknowledge inputs are stable around each rising edge, and reset is applied before the first check. The interrupt properties also assume that vec_ack_i is meaningful only as a one-cycle pulse. The stimulus drives every input one time unit after a rising edge and holds it for a full cycle. It pulses vec_ack_i for a single cycle, sometimes in the same cycle as a new CPU violation. It never writes a register in the same cycle as an access whose outcome depends on that register.

// File: rtl/mpu_guard_pkg.sv
`timescale 1ns/1ps
package mpu_guard_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam int FLD_LO      = 0;
  localparam int FLD_HI      = 1;
  localparam int FLD_ATTR    = 2;
  localparam int ATTR_WP_BIT = 8;
  localparam int ATTR_NX_BIT = 9;
endpackage

// File: rtl/mpu_guard_regs.sv
`timescale 1ns/1ps
module mpu_guard_regs
  import mpu_guard_pkg::*;
#(
  parameter int NUM_DESC    = 8,
  parameter int NUM_MASTERS = 3,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int REG_AW      = 6
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     we_i,
  input  logic [REG_AW-1:0]                        waddr_i,
  input  logic [DATA_W-1:0]                        wdata_i,
  output logic [NUM_DESC-1:0][ADDR_W-1:0]          lo_o,
  output logic [NUM_DESC-1:0][ADDR_W-1:0]          hi_o,
  output logic [NUM_DESC-1:0][NUM_MASTERS-1:0]     men_o,
  output logic [NUM_DESC-1:0]                      wp_o,
  output logic [NUM_DESC-1:0]                      nx_o,
  output logic                                     sup_en_o
);
  localparam logic [REG_AW-1:0] CTRL_A = REG_AW'(NUM_DESC * 4);

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  for (genvar d = 0; d < NUM_DESC; d++) begin : g_desc
    localparam logic [REG_AW-1:0] BASE = REG_AW'(4 * d);
    logic [ADDR_W-1:0]      lo_q, hi_q;
    logic [NUM_MASTERS-1:0] men_q;
    logic                   wp_q, nx_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q  <= '0;
        hi_q  <= '1;
        men_q <= (d == 0) ? {NUM_MASTERS{1'b1}} : '0;
        wp_q  <= 1'b0;
        nx_q  <= 1'b0;
      end else if (we_i) begin
        if (waddr_i == BASE + REG_AW'(FLD_LO)) lo_q <= wdata_i[ADDR_W-1:0];
        if (waddr_i == BASE + REG_AW'(FLD_HI)) hi_q <= wdata_i[ADDR_W-1:0];
        if (waddr_i == BASE + REG_AW'(FLD_ATTR)) begin
          men_q <= wdata_i[NUM_MASTERS-1:0];
          wp_q  <= wdata_i[ATTR_WP_BIT];
          nx_q  <= wdata_i[ATTR_NX_BIT];
        end
      end
    end

    assign lo_o[d]  = lo_q;
    assign hi_o[d]  = hi_q;
    assign men_o[d] = men_q;
    assign wp_o[d]  = wp_q;
    assign nx_o[d]  = nx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         sup_en_o <= 1'b0;
    else if (we_i && waddr_i == CTRL_A)  sup_en_o <= wdata_i[0];
  end
endmodule

// File: rtl/mpu_guard_match.sv
`timescale 1ns/1ps
module mpu_guard_match
  import mpu_guard_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NUM_MASTERS = 3,
  parameter int MID_W       = 2
) (
  input  logic [ADDR_W-1:0]      lo_i,
  input  logic [ADDR_W-1:0]      hi_i,
  input  logic [NUM_MASTERS-1:0] men_i,
  input  logic                   wp_i,
  input  logic                   nx_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [MID_W-1:0]       mid_i,
  input  acc_kind_e              kind_i,
  output logic                   permit_o
);
  logic in_range, master_ok, kind_ok;

  assign in_range  = (addr_i >= lo_i) && (addr_i <= hi_i);
  assign master_ok = (int'(mid_i) < NUM_MASTERS) && men_i[mid_i];
  assign kind_ok   = !((kind_i == ACC_WRITE && wp_i) || (kind_i == ACC_FETCH && nx_i));
  assign permit_o  = in_range && master_ok && kind_ok;
endmodule

// File: rtl/mpu_guard_event.sv
`timescale 1ns/1ps
module mpu_guard_event #(
  parameter int ADDR_W = 16,
  parameter int MID_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              viol_i,
  input  logic              cpu_viol_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MID_W-1:0]  mid_i,
  input  logic              clr_i,
  input  logic              ack_i,
  output logic              err_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [MID_W-1:0]  cap_mid_o,
  output logic              irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o      <= 1'b0;
      cap_addr_o <= '0;
      cap_mid_o  <= '0;
      irq_o      <= 1'b0;
    end else begin
      // capture freezes while the flag is up
      if (viol_i && !err_o) begin
        cap_addr_o <= addr_i;
        cap_mid_o  <= mid_i;
      end
      if (viol_i)     err_o <= 1'b1;
      else if (clr_i) err_o <= 1'b0;
      // request follows vector fetch, not the flag
      if (cpu_viol_i) irq_o <= 1'b1;
      else if (ack_i) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mpu_guard.sv
`timescale 1ns/1ps
module mpu_guard
  import mpu_guard_pkg::*;
#(
  parameter  int NUM_DESC    = 8,
  parameter  int NUM_MASTERS = 3,
  parameter  int ADDR_W      = 16,
  parameter  int DATA_W      = 16,
  parameter  int CPU_ID      = 0,
  localparam int MID_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int REG_AW      = $clog2(NUM_DESC * 4 + 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              acc_valid_i,
  input  logic [MID_W-1:0]  acc_master_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_kind_i,
  input  logic              acc_super_i,
  output logic              acc_allow_o,
  output logic              irq_o,
  input  logic              vec_ack_i
);
  localparam int DIDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1;
  localparam logic [REG_AW-1:0] CTRL_A = REG_AW'(NUM_DESC * 4);
  localparam logic [REG_AW-1:0] STAT_A = REG_AW'(NUM_DESC * 4 + 1);
  localparam logic [REG_AW-1:0] CAPA_A = REG_AW'(NUM_DESC * 4 + 2);
  localparam logic [REG_AW-1:0] CAPM_A = REG_AW'(NUM_DESC * 4 + 3);

  logic [NUM_DESC-1:0][ADDR_W-1:0]      lo, hi;
  logic [NUM_DESC-1:0][NUM_MASTERS-1:0] men;
  logic [NUM_DESC-1:0]                  wp, nx, permit;
  logic                                 sup_en, err_q, bypass, hit, viol, cpu_viol, clr;
  logic [ADDR_W-1:0]                    cap_addr;
  logic [MID_W-1:0]                     cap_mid;
  acc_kind_e                            kind;

  assign kind = acc_kind_e'(acc_kind_i);

  mpu_guard_regs #(
    .NUM_DESC(NUM_DESC), .NUM_MASTERS(NUM_MASTERS), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .REG_AW(REG_AW)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .waddr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .lo_o(lo), .hi_o(hi), .men_o(men), .wp_o(wp), .nx_o(nx), .sup_en_o(sup_en)
  );

  for (genvar d = 0; d < NUM_DESC; d++) begin : g_match
    mpu_guard_match #(
      .ADDR_W(ADDR_W), .NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W)
    ) u_match (
      .lo_i(lo[d]), .hi_i(hi[d]), .men_i(men[d]), .wp_i(wp[d]), .nx_i(nx[d]),
      .addr_i(acc_addr_i), .mid_i(acc_master_i), .kind_i(kind),
      .permit_o(permit[d])
    );
  end

  assign hit         = |permit;
  assign bypass      = (int'(acc_master_i) == CPU_ID) && acc_super_i && !sup_en;
  assign acc_allow_o = acc_valid_i && (hit || bypass);
  assign viol        = acc_valid_i && !(hit || bypass);
  assign cpu_viol    = viol && (int'(acc_master_i) == CPU_ID);
  assign clr         = reg_we_i && (reg_addr_i == STAT_A) && reg_wdata_i[0];

  mpu_guard_event #(.ADDR_W(ADDR_W), .MID_W(MID_W)) u_event (
    .clk_i, .rst_ni,
    .viol_i(viol), .cpu_viol_i(cpu_viol),
    .addr_i(acc_addr_i), .mid_i(acc_master_i),
    .clr_i(clr), .ack_i(vec_ack_i),
    .err_o(err_q), .cap_addr_o(cap_addr), .cap_mid_o(cap_mid), .irq_o(irq_o)
  );

  logic [DIDX_W-1:0] rd_idx;
  assign rd_idx = DIDX_W'(reg_addr_i >> 2);

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i < CTRL_A) begin
      case (reg_addr_i[1:0])
        2'd0: reg_rdata_o[ADDR_W-1:0] = lo[rd_idx];
        2'd1: reg_rdata_o[ADDR_W-1:0] = hi[rd_idx];
        2'd2: begin
          reg_rdata_o[NUM_MASTERS-1:0] = men[rd_idx];
          reg_rdata_o[ATTR_WP_BIT]     = wp[rd_idx];
          reg_rdata_o[ATTR_NX_BIT]     = nx[rd_idx];
        end
        default: ;
      endcase
    end else begin
      case (reg_addr_i)
        CTRL_A:  reg_rdata_o[0] = sup_en;
        STAT_A:  reg_rdata_o[0] = err_q;
        CAPA_A:  reg_rdata_o[ADDR_W-1:0] = cap_addr;
        CAPM_A:  reg_rdata_o[MID_W-1:0] = cap_mid;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mpu_guard_chk.sv
`timescale 1ns/1ps
module mpu_guard_chk #(
  parameter int ADDR_W = 16,
  parameter int MID_W  = 2,
  parameter int CPU_ID = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic [MID_W-1:0]  acc_master_i,
  input logic              acc_super_i,
  input logic              acc_allow_o,
  input logic              sup_en,
  input logic              viol,
  input logic              cpu_viol,
  input logic              err_q,
  input logic              irq_o,
  input logic              vec_ack_i,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [MID_W-1:0]  cap_mid
);
  // R7
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol |=> err_q);
  // R8
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_viol |=> irq_o);
  // R8
  irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && vec_ack_i && !cpu_viol) |=> !irq_o);
  // R9
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !cpu_viol) |=> !irq_o);
  // R10
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> ($stable(cap_addr) && $stable(cap_mid)));
  // R6
  sup_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && int'(acc_master_i) == CPU_ID && acc_super_i && !sup_en) |-> acc_allow_o);
  // R11
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> !acc_allow_o);
endmodule

bind mpu_guard mpu_guard_chk #(.ADDR_W(ADDR_W), .MID_W(MID_W), .CPU_ID(CPU_ID)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_valid_i(acc_valid_i), .acc_master_i(acc_master_i),
  .acc_super_i(acc_super_i), .acc_allow_o(acc_allow_o), .sup_en(sup_en), .viol(viol),
  .cpu_viol(cpu_viol), .err_q(err_q), .irq_o(irq_o), .vec_ack_i(vec_ack_i),
  .cap_addr(cap_addr), .cap_mid(cap_mid)
);

// File: tb/mpu_guard_bench.sv
`timescale 1ns/1ps
module mpu_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_master = '0;
  logic [15:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_super = 1'b0;
  logic        acc_allow;
  logic        irq;
  logic        vec_ack = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mpu_guard u_mpu_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .acc_valid_i(acc_valid), .acc_master_i(acc_master), .acc_addr_i(acc_addr),
    .acc_kind_i(acc_kind), .acc_super_i(acc_super), .acc_allow_o(acc_allow),
    .irq_o(irq), .vec_ack_i(vec_ack)
  );

  // reference model
  int m_lo[8], m_hi[8], m_men[8];
  bit m_wp[8], m_nx[8];
  bit m_sup, m_err, m_irq;
  int m_capa, m_capm;

  function automatic bit ref_legal(int m, int a, int k, bit s);
    if (m == 0 && s && !m_sup) return 1;
    for (int d = 0; d < 8; d++) begin
      if (a >= m_lo[d] && a <= m_hi[d] && m < 3 && m_men[d][m] &&
          !(k == 1 && m_wp[d]) && !(k == 2 && m_nx[d])) return 1;
    end
    return 0;
  endfunction

  function automatic int ref_read(int a);
    if (a < 32) begin
      case (a % 4)
        0: return m_lo[a/4];
        1: return m_hi[a/4];
        2: return m_men[a/4] | (int'(m_wp[a/4]) << 8) | (int'(m_nx[a/4]) << 9);
        default: return 0;
      endcase
    end
    case (a)
      32: return int'(m_sup);
      33: return int'(m_err);
      34: return m_capa;
      35: return m_capm;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < 8; d++) begin
        m_lo[d] = 0; m_hi[d] = 16'hFFFF; m_men[d] = (d == 0) ? 7 : 0;
        m_wp[d] = 0; m_nx[d] = 0;
      end
      m_sup = 0; m_err = 0; m_irq = 0; m_capa = 0; m_capm = 0;
    end else begin
      bit v, c, clr;
      v   = acc_valid && !ref_legal(int'(acc_master), int'(acc_addr), int'(acc_kind), acc_super);
      c   = v && acc_master == 0;
      clr = reg_we && reg_addr == 33 && reg_wdata[0];
      if (v && !m_err) begin m_capa = int'(acc_addr); m_capm = int'(acc_master); end
      if (v) m_err = 1; else if (clr) m_err = 0;
      if (c) m_irq = 1; else if (vec_ack) m_irq = 0;
      if (reg_we) begin
        if (reg_addr < 32) begin
          case (reg_addr % 4)
            0: m_lo[reg_addr/4] = int'(reg_wdata);
            1: m_hi[reg_addr/4] = int'(reg_wdata);
            2: begin
              m_men[reg_addr/4] = int'(reg_wdata[2:0]);
              m_wp[reg_addr/4]  = reg_wdata[8];
              m_nx[reg_addr/4]  = reg_wdata[9];
            end
            default: ;
          endcase
        end else if (reg_addr == 32) m_sup = reg_wdata[0];
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // model comparison every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 allow vs model", int'(acc_allow),
          int'(acc_valid && ref_legal(int'(acc_master), int'(acc_addr), int'(acc_kind), acc_super)));
      chk("R8 irq vs model", int'(irq), int'(m_irq));
      chk("R10 rdata vs model", int'(reg_rdata), ref_read(int'(reg_addr)));
    end
  end

  task automatic clear_in();
    reg_we = 0; reg_addr = '0; reg_wdata = '0; acc_valid = 0; acc_master = '0;
    acc_addr = '0; acc_kind = '0; acc_super = 0; vec_ack = 0;
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #1; clear_in();
    reg_we = 1; reg_addr = 6'(a); reg_wdata = 16'(d);
  endtask

  task automatic rd(int a, int exp, string tag);
    @(posedge clk); #1; clear_in();
    reg_addr = 6'(a);
    @(negedge clk);
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic acc(int m, int a, int k, bit s, bit ack, int exp, string tag);
    @(posedge clk); #1; clear_in();
    acc_valid = 1; acc_master = 2'(m); acc_addr = 16'(a); acc_kind = 2'(k);
    acc_super = s; vec_ack = ack;
    @(negedge clk);
    chk(tag, int'(acc_allow), exp);
  endtask

  task automatic idle_chk_irq(int exp, string tag);
    @(posedge clk); #1; clear_in();
    @(negedge clk);
    chk(tag, int'(irq), exp);
  endtask

  task automatic ack_pulse();
    @(posedge clk); #1; clear_in();
    vec_ack = 1;
  endtask

  initial begin
    clear_in();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(0, 0, "R1 desc0 lower");
    rd(1, 16'hFFFF, "R1 desc0 upper");
    rd(2, 7, "R1 desc0 attr");
    rd(6, 0, "R1 desc1 attr");
    rd(33, 0, "R1 status");
    for (int m = 0; m < 3; m++)
      for (int k = 0; k < 3; k++)
        acc(m, 16'hBEEF, k, 0, 0, 1, "R1 open access");
    idle_chk_irq(0, "R1 irq idle");

    // program regions
    wr(0, 16'h0000); wr(1, 16'h3FFF); wr(2, 16'h0003);
    wr(4, 16'h4000); wr(5, 16'h7FFF); wr(6, 16'h0107);
    wr(8, 16'h8000); wr(9, 16'h8FFF); wr(10, 16'h0207);
    wr(12, 16'h8800); wr(13, 16'h9000); wr(14, 16'h0001);
    rd(6, 16'h0107, "R2 attr readback");

    acc(1, 16'h3FFF, 0, 0, 0, 1, "R2 upper bound inclusive");
    acc(0, 16'h0000, 0, 0, 0, 1, "R2 lower bound inclusive");
    acc(0, 16'h4000, 0, 0, 0, 1, "R3 read in write-protected");
    acc(1, 16'h4000, 2, 0, 0, 1, "R3 fetch in write-protected");
    acc(0, 16'h8000, 0, 0, 0, 1, "R4 read in no-exec");
    acc(0, 16'h8800, 2, 0, 0, 1, "R5 overlap grants fetch");
    acc(0, 16'h9000, 2, 0, 0, 1, "R5 overlap upper");
    acc(0, 16'h4000, 1, 1, 0, 1, "R6 supervisor bypass");
    acc(2, 16'h4000, 1, 1, 0, 0, "R6 bypass only for CPU");
    idle_chk_irq(0, "R8 non-CPU no irq");
    rd(34, 16'h4000, "R10 capture addr");
    rd(35, 2, "R10 capture master");
    wr(33, 1);
    rd(33, 0, "R10 flag cleared");

    acc(2, 16'h0010, 0, 0, 0, 0, "R2 master not enabled");
    rd(33, 1, "R7 flag set");
    rd(34, 16'h0010, "R10 capture addr");
    rd(35, 2, "R10 capture master");
    acc(1, 16'h8000, 2, 0, 0, 0, "R4 fetch no-exec denied");
    rd(34, 16'h0010, "R10 capture frozen");
    acc(0, 16'h4000, 1, 0, 0, 0, "R3 write denied");
    idle_chk_irq(1, "R8 irq raised");
    idle_chk_irq(1, "R8 irq held");
    idle_chk_irq(1, "R8 irq held");
    ack_pulse();
    idle_chk_irq(0, "R8 irq dropped on ack");
    rd(33, 1, "R9 flag still set");
    idle_chk_irq(0, "R9 no re-raise");
    idle_chk_irq(0, "R9 no re-raise");
    wr(33, 1);
    rd(33, 0, "R10 W1C clears");

    wr(32, 1);
    rd(32, 1, "R6 ctrl set");
    acc(0, 16'h4000, 1, 1, 0, 0, "R6 supervisor checked");
    idle_chk_irq(1, "R8 irq raised");
    rd(34, 16'h4000, "R10 new capture");
    rd(35, 0, "R10 new capture master");
    acc(0, 16'h8000, 2, 0, 1, 0, "R4 CPU fetch denied");
    idle_chk_irq(1, "R8 new viol beats ack");
    ack_pulse();
    idle_chk_irq(0, "R8 ack clears");
    acc(0, 16'h8810, 0, 0, 0, 1, "R11 same-cycle allow");
    @(posedge clk); #1; clear_in();
    @(negedge clk);
    chk("R11 idle low", int'(acc_allow), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule